// File: doc/BRIEF.md
# ATM Transmit Cell Formatter

This block sits between an ATM layer and a line-side framer. The ATM layer writes 53-byte cells, one byte per cycle, into a small cell FIFO. On the other side the framer pulls a continuous byte stream, one byte for each cycle in which it raises its byte strobe. A cell becomes eligible for sending only once all 53 of its bytes are in the FIFO.

At each cell boundary the formatter checks whether a complete cell is queued. If none is, it sends a rate-decoupling cell instead. That cell is either idle or unassigned, and its 48 payload bytes all carry a configurable pattern. The fifth header byte can be replaced by a CRC-8 header check. That check is XORed with a programmable coset, and one bit of it can be flipped on purpose for line testing. Payload bytes can pass through a self-synchronising scrambler that leaves headers alone.

The FIFO depth is selectable as 2, 3 or 4 cells. This sets how much latency the queue can add. A status output shows when room for two more cells exists. A saturating counter records how many user cells left the block with a correct header check.

Top module: `cell_tx_fmt`

## Requirements
- R1: `cfg_depth` sets the cell limit: code 0 gives 2 cells, code 1 gives 3, and codes 2 and 3 give 4. `wr_ready` is high exactly when fewer complete cells than the limit are queued. A cell stays queued until its last byte has been sent. Writes while `wr_ready` is low are dropped.
- R2: `room2` is high exactly when the limit minus the queued complete cells is 2 or more.
- R3: User cells leave in write order with their bytes unchanged, apart from the HEC byte (index 4) and scrambled payload. A partly written cell is never sent; a fill cell goes out in its place.
- R4: At a cell boundary with no complete cell queued, a fill cell is sent. Its header bytes 0..3 are 00 00 00 01 when `cfg_fill_unassigned`=0 (idle) and 00 00 00 00 when it is 1 (unassigned).
- R5: All 48 payload bytes (indexes 5..52) of a fill cell equal `cfg_fill_byte` before scrambling.
- R6: Byte 4 is CRC-8 (generator x^8+x^2+x+1, initial value 0, most significant bit first) over bytes 0..3, XORed with `cfg_coset`. This applies to fill cells always and to user cells when `cfg_hec_en`=1. With `cfg_hec_en`=0, a user cell's own byte 4 passes unchanged.
- R7: With `cfg_hec_en`=1 and `cfg_hec_err`=1 at a cell's first byte, bit 0 of that cell's inserted byte 4 is inverted.
- R8: With `cfg_scr_en`=1, each payload bit is processed most significant bit first. The bit sent equals the input bit XOR the bit sent 43 payload bits earlier. The history starts at zero after reset, carries over from one cell to the next, and advances only on scrambled payload bytes. Header bytes are never scrambled.
- R9: Each cycle with `tx_en`=1 produces one byte in `tx_data` at the next clock edge, with `tx_dv`=1. `tx_soc` is 1 only on byte 0 of a cell. `tx_dv` is 0 after any edge where `tx_en` was 0.
- R10: `cell_count` increases by one when the last byte of a user cell is sent, unless that cell carried an injected HEC error. It holds at its all-ones value.
- R11: After reset the FIFO is empty: `wr_ready`=1, `room2`=1, `tx_dv`=0, `tx_soc`=0 and `cell_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write byte strobe from the ATM layer |
| wr_data | input | 8 | Cell byte being written |
| wr_ready | output | 1 | A cell slot is free for writing |
| room2 | output | 1 | Space for at least two more cells |
| tx_en | input | 1 | Framer requests one byte |
| tx_data | output | 8 | Outgoing cell byte |
| tx_dv | output | 1 | `tx_data` holds a new byte |
| tx_soc | output | 1 | Current byte is byte 0 of a cell |
| cfg_depth | input | 2 | Cell limit code |
| cfg_fill_unassigned | input | 1 | Fill cells are unassigned (1) or idle (0) |
| cfg_fill_byte | input | 8 | Fill cell payload pattern |
| cfg_scr_en | input | 1 | Enable payload scrambling |
| cfg_hec_en | input | 1 | Insert HEC into user cells |
| cfg_coset | input | 8 | Value XORed into the HEC |
| cfg_hec_err | input | 1 | Invert bit 0 of the inserted HEC |
| cell_count | output | CNT_W | Saturating count of good user cells sent |

## Verification
The assertions assume a few things about the inputs. The configuration stays steady while a cell is in flight. `cfg_depth` is never lowered below the number of cells already queued. `wr_valid` is only raised when the writer intends a byte to count. The stimulus meets these conditions by changing configuration only between rounds, with the byte strobe idle and every cell sent in full. Writes are issued only while `wr_ready` is high, except when a full FIFO is being probed. The random rounds draw cell contents, cell counts, depth codes and option bits from a seeded generator. Directed cases cover a completely full FIFO, a half-written cell and counter saturation.

// File: rtl/cell_tx_pkg.sv
package cell_tx_pkg;

    localparam int CELL_BYTES = 53;
    localparam int HDR_BYTES  = 5;
    localparam int HEC_IDX    = 4;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        LIM_TWO   = 2'd0,
        LIM_THREE = 2'd1,
        LIM_FOUR  = 2'd2,
        LIM_FOUR2 = 2'd3
    } depth_code_e;

    typedef struct packed {
        logic user;    // cell comes from the FIFO
        logic hec_on;  // header check replaced in a user cell
        logic inj;     // bit 0 of the inserted check is inverted
    } cell_ctx_t;

    function automatic int unsigned depth_cells(depth_code_e code);
        case (code)
            LIM_TWO:   return 2;
            LIM_THREE: return 3;
            default:   return 4;
        endcase
    endfunction

    function automatic byte_t crc8_step(byte_t crc, byte_t d);
        byte_t c;
        logic  fb;
        c = crc;
        for (int i = 7; i >= 0; i--) begin
            fb = c[7] ^ d[i];
            c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return c;
    endfunction

    function automatic byte_t fill_header(logic [5:0] idx, logic unassigned);
        return (idx == 6'd3 && !unassigned) ? 8'h01 : 8'h00;
    endfunction

endpackage

// File: rtl/cell_fifo.sv
module cell_fifo
    import cell_tx_pkg::*;
#(
    parameter int MAX_CELLS = 4,
    localparam int CW = $clog2(MAX_CELLS + 1),
    localparam int PW = (MAX_CELLS > 1) ? $clog2(MAX_CELLS) : 1,
    localparam int BW = $clog2(CELL_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] limit,
    input  logic          wr_valid,
    input  byte_t         wr_data,
    output logic          wr_ready,
    output logic          room2,
    input  logic [BW-1:0] rd_idx,
    output byte_t         rd_data,
    input  logic          rd_done,
    output logic          avail
);

    byte_t         mem [MAX_CELLS][CELL_BYTES];
    logic [PW-1:0] wr_cell, rd_cell;
    logic [BW-1:0] wr_byte;
    logic [CW-1:0] occ;
    logic          wr_fire, commit;

    assign wr_ready = occ < limit;
    assign room2    = ({1'b0, occ} + (CW+1)'(2)) <= {1'b0, limit};
    assign avail    = occ != '0;
    assign wr_fire  = wr_valid && wr_ready;
    assign commit   = wr_fire && (wr_byte == BW'(CELL_BYTES - 1));
    assign rd_data  = mem[rd_cell][rd_idx];

    always_ff @(posedge clk) begin
        if (wr_fire) mem[wr_cell][wr_byte] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_cell <= '0;
            rd_cell <= '0;
            wr_byte <= '0;
            occ     <= '0;
        end else begin
            if (wr_fire) wr_byte <= commit ? '0 : wr_byte + 1'b1;
            if (commit)
                wr_cell <= (wr_cell == PW'(MAX_CELLS - 1)) ? '0 : wr_cell + 1'b1;
            if (rd_done)
                rd_cell <= (rd_cell == PW'(MAX_CELLS - 1)) ? '0 : rd_cell + 1'b1;
            occ <= occ + CW'(commit) - CW'(rd_done);
        end
    end

    // R3
    pop_needs_cell_chk: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> occ != '0);

    // R1
    occ_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (occ == $past(occ) || occ == $past(occ) + CW'(1) || occ == $past(occ) - CW'(1)));

    // R1
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(MAX_CELLS));

endmodule

// File: rtl/tx_scrambler.sv
module tx_scrambler
    import cell_tx_pkg::*;
#(
    parameter int LEN = 43
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  advance,
    input  byte_t din,
    output byte_t dout
);

    logic [LEN-1:0] hist_q, hist_n;

    always_comb begin
        hist_n = hist_q;
        dout   = '0;
        for (int i = 7; i >= 0; i--) begin
            dout[i] = din[i] ^ hist_n[LEN-1];
            hist_n  = {hist_n[LEN-2:0], dout[i]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          hist_q <= '0;
        else if (advance) hist_q <= hist_n;
    end

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst)                     cnt <= '0;
        else if (inc && cnt != '1)   cnt <= cnt + 1'b1;
    end

    // R10
    cnt_sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == '1) |=> (cnt == '1));

    // R10
    cnt_no_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc) |=> $stable(cnt));

endmodule

// File: rtl/cell_tx_fmt.sv
module cell_tx_fmt
    import cell_tx_pkg::*;
#(
    parameter int MAX_CELLS = 4,
    parameter int CNT_W     = 16,
    parameter int SCR_LEN   = 43
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    output logic             wr_ready,
    output logic             room2,
    input  logic             tx_en,
    output logic [7:0]       tx_data,
    output logic             tx_dv,
    output logic             tx_soc,
    input  logic [1:0]       cfg_depth,
    input  logic             cfg_fill_unassigned,
    input  logic [7:0]       cfg_fill_byte,
    input  logic             cfg_scr_en,
    input  logic             cfg_hec_en,
    input  logic [7:0]       cfg_coset,
    input  logic             cfg_hec_err,
    output logic [CNT_W-1:0] cell_count
);

    localparam int CW = $clog2(MAX_CELLS + 1);
    localparam int BW = $clog2(CELL_BYTES);

    logic [CW-1:0] limit;
    logic [BW-1:0] idx_q;
    cell_ctx_t     ctx_q, ctx_now;
    byte_t         crc_q, crc_in, crc_nx;
    byte_t         rd_data, raw, hec_byte, scr_out, out_byte;
    logic          avail, at_start, at_last, is_pay, rd_done, scr_adv;

    always_comb begin
        int unsigned lim;
        lim = depth_cells(depth_code_e'(cfg_depth));
        if (lim > MAX_CELLS) lim = MAX_CELLS;
        limit = CW'(lim);
    end

    cell_fifo #(.MAX_CELLS(MAX_CELLS)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .limit    (limit),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .wr_ready (wr_ready),
        .room2    (room2),
        .rd_idx   (idx_q),
        .rd_data  (rd_data),
        .rd_done  (rd_done),
        .avail    (avail)
    );

    assign at_start = idx_q == '0;
    assign at_last  = idx_q == BW'(CELL_BYTES - 1);
    assign is_pay   = idx_q >= BW'(HDR_BYTES);

    always_comb begin
        if (at_start) begin
            ctx_now.user   = avail;
            ctx_now.hec_on = cfg_hec_en;
            ctx_now.inj    = cfg_hec_en && cfg_hec_err;
        end else begin
            ctx_now = ctx_q;
        end
    end

    always_comb begin
        if (ctx_now.user)       raw = rd_data;
        else if (!is_pay)       raw = fill_header(6'(idx_q), cfg_fill_unassigned);
        else                    raw = cfg_fill_byte;
    end

    assign crc_in   = at_start ? 8'h00 : crc_q;
    assign crc_nx   = crc8_step(crc_in, raw);
    assign hec_byte = crc_q ^ cfg_coset ^ {7'b0, ctx_now.inj};
    assign scr_adv  = tx_en && is_pay && cfg_scr_en;

    tx_scrambler #(.LEN(SCR_LEN)) u_scr (
        .clk     (clk),
        .rst     (rst),
        .advance (scr_adv),
        .din     (raw),
        .dout    (scr_out)
    );

    always_comb begin
        if (idx_q == BW'(HEC_IDX))
            out_byte = (ctx_now.user && !ctx_now.hec_on) ? raw : hec_byte;
        else if (is_pay)
            out_byte = cfg_scr_en ? scr_out : raw;
        else
            out_byte = raw;
    end

    assign rd_done = tx_en && at_last && ctx_now.user;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            ctx_q   <= '0;
            crc_q   <= '0;
            tx_data <= '0;
            tx_dv   <= 1'b0;
            tx_soc  <= 1'b0;
        end else begin
            tx_dv  <= tx_en;
            tx_soc <= tx_en && at_start;
            if (tx_en) begin
                idx_q   <= at_last ? '0 : idx_q + 1'b1;
                ctx_q   <= ctx_now;
                tx_data <= out_byte;
                if (idx_q < BW'(HEC_IDX)) crc_q <= crc_nx;
            end
        end
    end

    sat_counter #(.W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (rd_done && !ctx_now.inj),
        .cnt (cell_count)
    );

    // R9
    soc_with_dv_chk: assert property (@(posedge clk) disable iff (rst)
        tx_soc |-> tx_dv);

    // R9
    dv_follows_en_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> !tx_dv);

    // R2
    room2_implies_ready_chk: assert property (@(posedge clk) disable iff (rst)
        room2 |-> wr_ready);

endmodule

// File: tb/cell_tx_fmt_bench.sv
`timescale 1ns/1ps
module cell_tx_fmt_bench;

    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst;
    logic wr_valid, wr_ready, room2, tx_en, tx_dv, tx_soc;
    logic [7:0] wr_data, tx_data;
    logic [1:0] cfg_depth;
    logic cfg_fill_unassigned, cfg_scr_en, cfg_hec_en, cfg_hec_err;
    logic [7:0] cfg_fill_byte, cfg_coset;
    logic [CNT_W-1:0] cell_count;

    always #2.5 clk = ~clk;

    cell_tx_fmt #(.CNT_W(CNT_W)) u_cell_tx_fmt (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .room2(room2), .tx_en(tx_en), .tx_data(tx_data),
        .tx_dv(tx_dv), .tx_soc(tx_soc), .cfg_depth(cfg_depth),
        .cfg_fill_unassigned(cfg_fill_unassigned), .cfg_fill_byte(cfg_fill_byte),
        .cfg_scr_en(cfg_scr_en), .cfg_hec_en(cfg_hec_en), .cfg_coset(cfg_coset),
        .cfg_hec_err(cfg_hec_err), .cell_count(cell_count)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0]  cells [4][53];
    logic [7:0]  expc  [53];
    logic [7:0]  gd    [318];
    logic        gs    [318];
    logic        gv    [318];
    logic [42:0] bs = '0;
    int          exp_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) r = {r[6:0], 1'b0} ^ ((r[7] ^ d[i]) ? 8'h07 : 8'h00);
        return r;
    endfunction

    function automatic int lim_of(input logic [1:0] code);
        return (code == 2'd0) ? 2 : (code == 2'd1) ? 3 : 4;
    endfunction

    task automatic scr_step(input logic [7:0] d, output logic [7:0] o);
        for (int i = 7; i >= 0; i--) begin
            o[i] = d[i] ^ bs[42];
            bs   = {bs[41:0], o[i]};
        end
    endtask

    task automatic exp_cell(input bit user, input int slot);
        logic [7:0] crc;
        crc = 8'h00;
        for (int i = 0; i < 53; i++) begin
            logic [7:0] r;
            if (user)       r = cells[slot][i];
            else if (i < 3) r = 8'h00;
            else if (i == 3) r = cfg_fill_unassigned ? 8'h00 : 8'h01;
            else            r = cfg_fill_byte;
            if (i < 4) begin
                crc = crc_step(crc, r);
                expc[i] = r;
            end else if (i == 4) begin
                expc[i] = (user && !cfg_hec_en) ? r
                        : crc ^ cfg_coset ^ {7'b0, cfg_hec_en & cfg_hec_err};
            end else if (cfg_scr_en) begin
                scr_step(r, expc[i]);
            end else begin
                expc[i] = r;
            end
        end
    endtask

    function automatic string tag_of(input bit user, input int i);
        if (i == 4)             return (cfg_hec_en && cfg_hec_err) ? "R7" : "R6";
        if (i >= 5 && cfg_scr_en) return "R8";
        if (user)               return "R3";
        return (i < 4) ? "R4" : "R5";
    endfunction

    task automatic write_bytes(input int slot, input int from, input int upto);
        for (int i = from; i < upto; i++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            wr_data  = cells[slot][i];
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic stream(input int ncell);
        @(negedge clk);
        tx_en = 1'b1;
        for (int k = 0; k < ncell * 53; k++) begin
            @(posedge clk);
            @(negedge clk);
            gd[k] = tx_data;
            gs[k] = tx_soc;
            gv[k] = tx_dv;
            if (k == ncell * 53 - 1) tx_en = 1'b0;
        end
        @(negedge clk);
        chk(tx_dv == 1'b0, "R9", "tx_dv after strobe stops", int'(tx_dv), 0);
    endtask

    task automatic compare(input int ncell, input int nuser);
        for (int j = 0; j < ncell; j++) begin
            bit user, ok, fr_ok;
            int bad;
            user  = (j < nuser);
            exp_cell(user, j);
            ok    = 1'b1;
            fr_ok = 1'b1;
            bad   = 0;
            for (int i = 0; i < 53; i++) begin
                if (ok && gd[j*53+i] !== expc[i]) begin ok = 1'b0; bad = i; end
                if (gs[j*53+i] !== (i == 0) || gv[j*53+i] !== 1'b1) fr_ok = 1'b0;
            end
            chk(ok, tag_of(user, bad), $sformatf("cell %0d byte %0d", j, bad),
                int'(gd[j*53+bad]), int'(expc[bad]));
            chk(fr_ok, "R9", $sformatf("cell %0d soc/dv framing", j), int'(gs[j*53]), 1);
            if (user && !(cfg_hec_en && cfg_hec_err) && exp_cnt < 15) exp_cnt++;
        end
        chk(cell_count == CNT_W'(exp_cnt), "R10", "cell_count", int'(cell_count), exp_cnt);
    endtask

    task automatic rand_cfg();
        cfg_fill_unassigned = 1'($urandom);
        cfg_fill_byte       = 8'($urandom);
        cfg_scr_en          = 1'($urandom);
        cfg_hec_en          = 1'($urandom);
        cfg_coset           = ($urandom % 2) ? 8'h55 : 8'($urandom);
        cfg_hec_err         = ($urandom % 4) == 0;
    endtask

    task automatic run_round(input int n, input int extra);
        int lim;
        lim = lim_of(cfg_depth);
        for (int c = 0; c < n; c++) begin
            for (int i = 0; i < 53; i++) cells[c][i] = 8'($urandom);
            chk(wr_ready == 1'b1, "R1", "wr_ready below limit", int'(wr_ready), 1);
            chk(room2 == ((lim - c) >= 2), "R2", "room2 before write", int'(room2), int'((lim - c) >= 2));
            write_bytes(c, 0, 53);
        end
        chk(wr_ready == (n < lim), "R1", "wr_ready after writes", int'(wr_ready), int'(n < lim));
        chk(room2 == ((lim - n) >= 2), "R2", "room2 after writes", int'(room2), int'((lim - n) >= 2));
        stream(n + extra);
        compare(n + extra, n);
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; wr_valid = 1'b0; wr_data = '0; tx_en = 1'b0;
        cfg_depth = 2'd2; cfg_fill_unassigned = 1'b0; cfg_fill_byte = 8'h6A;
        cfg_scr_en = 1'b0; cfg_hec_en = 1'b1; cfg_coset = 8'h55; cfg_hec_err = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(wr_ready == 1'b1, "R11", "wr_ready after reset", int'(wr_ready), 1);
        chk(room2 == 1'b1, "R11", "room2 after reset", int'(room2), 1);
        chk(tx_dv == 1'b0 && tx_soc == 1'b0, "R11", "tx_dv/tx_soc after reset", int'(tx_dv), 0);
        chk(cell_count == '0, "R11", "cell_count after reset", int'(cell_count), 0);

        // directed: idle fill with default coset, header check 0x52
        stream(1);
        compare(1, 0);
        chk(gd[4] == 8'h52, "R6", "idle cell HEC", int'(gd[4]), 8'h52);

        // directed: unassigned fill, header check 0x55
        cfg_fill_unassigned = 1'b1;
        stream(1);
        compare(1, 0);
        chk(gd[4] == 8'h55, "R6", "unassigned cell HEC", int'(gd[4]), 8'h55);

        // directed: fill the FIFO for every depth code (R1, R2)
        for (int d = 0; d < 4; d++) begin
            cfg_depth = 2'(d);
            rand_cfg();
            run_round(lim_of(2'(d)), 1);
        end

        // directed: write beyond a full FIFO is dropped (R1)
        cfg_depth = 2'd0;
        cfg_hec_err = 1'b0;
        for (int c = 0; c < 3; c++) begin
            for (int i = 0; i < 53; i++) cells[c][i] = 8'($urandom);
            write_bytes(c, 0, 53);
        end
        chk(wr_ready == 1'b0, "R1", "wr_ready with full FIFO", int'(wr_ready), 0);
        stream(3);
        compare(3, 2);

        // directed: a partial cell is held back (R3)
        cfg_depth = 2'd2;
        for (int i = 0; i < 53; i++) cells[0][i] = 8'($urandom);
        write_bytes(0, 0, 30);
        stream(1);
        compare(1, 0);
        write_bytes(0, 30, 53);
        stream(2);
        compare(2, 1);

        // directed: injected header error, bit 0 flipped (R7)
        cfg_hec_en = 1'b1; cfg_hec_err = 1'b1; cfg_scr_en = 1'b0;
        for (int i = 0; i < 53; i++) cells[0][i] = 8'($urandom);
        write_bytes(0, 0, 53);
        stream(1);
        compare(1, 1);
        cfg_hec_err = 1'b0;

        // random rounds
        for (int r = 0; r < 24; r++) begin
            int lim, n;
            cfg_depth = 2'($urandom);
            rand_cfg();
            lim = lim_of(cfg_depth);
            n = $urandom % (lim + 1);
            run_round(n, 1 + ($urandom % 2));
        end

        // saturation of the good-cell counter (R10)
        cfg_hec_err = 1'b0; cfg_depth = 2'd2;
        while (exp_cnt < 15) run_round(4, 0);
        run_round(2, 0);
        chk(cell_count == '1, "R10", "counter saturated", int'(cell_count), 15);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule